// File: doc/BRIEF.md
# Transceiver Loopback and All-Ones Router

This block steers the serial data streams of a transceiver between three neighbours: the line interface, the framer, and the system interface. In normal operation every stream passes straight through. On request it closes one of four loopbacks: analog (framer transmit output turned back into the framer receive input at the line edge), line (received line data sent straight back out to the line), diagnostic (framer transmit output fed back into the framer receive input), and payload (received framer payload returned to the framer transmit payload input). Three of these loopbacks can also replace the stream leaving in the opposite direction with an unframed all-ones signal.

The control inputs are sampled on a clock edge into a mode register. Line and diagnostic loopback may run together. Any other set of several requested loopbacks is reduced to one by a fixed priority. The resolved set is shown on a status output. Every data output is registered, so a mode change never causes a glitch on an output. Each stream is `DW` bits wide. With `DW = 1` a stream is a plain serial bit stream.

Top module: `lbr_router`

## Requirements
- R1: While `rst` is high, every data output and `lb_active` are cleared to zero on each clock edge.
- R2: With no loopback active, each data output equals its straight-through input from the previous cycle: `line_tx_out` follows `fr_tx_in`, `fr_rx_out` follows `line_rx_in`, `sys_rx_out` follows `fr_sys_rx_in`, and `fr_sys_tx_out` follows `sys_tx_in`.
- R3: In analog loopback, `fr_rx_out` carries `fr_tx_in` delayed by one cycle, and `line_tx_out` keeps carrying `fr_tx_in`.
- R4: In line loopback, `line_tx_out` carries `line_rx_in` delayed by one cycle, and `fr_rx_out` keeps carrying `line_rx_in`. If `cfg_line_ones` is set, `sys_rx_out` is all ones. Otherwise it carries `fr_sys_rx_in`.
- R5: In diagnostic loopback, `fr_rx_out` carries `fr_tx_in` delayed by one cycle. If `cfg_diag_ones` is set, `line_tx_out` is all ones. Otherwise it carries `fr_tx_in`.
- R6: When both line and diagnostic loopback are requested and analog is not, both are active together: `lb_active` reads 4'b0110, `line_tx_out` carries `line_rx_in`, and `fr_rx_out` carries `fr_tx_in`.
- R7: In payload loopback, `fr_sys_tx_out` carries `fr_sys_rx_in` delayed by one cycle. If `cfg_pay_ones` is set, `sys_rx_out` is all ones. Otherwise it carries `fr_sys_rx_in`.
- R8: `lb_active` bit 0 marks analog, bit 1 line, bit 2 diagnostic, and bit 3 payload. Apart from the combination in R6, only the highest-priority requested mode is active. The priority order is analog, then line, then diagnostic, then payload. A mode that is requested but not chosen has no effect on any output, and neither does its all-ones option.
- R9: Control inputs sampled at a clock edge appear on `lb_active` after that edge. The data outputs use the new mode from the following edge on. Data captured at the same edge still uses the previous mode.
- R10: When line and diagnostic loopback are both active and `cfg_diag_ones` is set, `line_tx_out` is all ones. The all-ones substitution takes precedence over the looped line data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_analog | input | 1 | Request analog loopback |
| cfg_line | input | 1 | Request line loopback |
| cfg_diag | input | 1 | Request diagnostic loopback |
| cfg_payload | input | 1 | Request payload loopback |
| cfg_line_ones | input | 1 | During line loopback, send all ones toward the system |
| cfg_diag_ones | input | 1 | During diagnostic loopback, send all ones toward the line |
| cfg_pay_ones | input | 1 | During payload loopback, send all ones toward the system |
| line_rx_in | input | DW | Data received from the line interface |
| fr_tx_in | input | DW | Framer transmit output |
| fr_sys_rx_in | input | DW | Framer received payload headed for the system |
| sys_tx_in | input | DW | System transmit payload headed for the framer |
| line_tx_out | output | DW | Data sent to the line interface |
| fr_rx_out | output | DW | Framer receive input |
| sys_rx_out | output | DW | Payload delivered to the system |
| fr_sys_tx_out | output | DW | Framer transmit payload input |
| lb_active | output | 4 | Resolved loopback set |

## Verification
On every cycle the assertions check the data relations that follow from the previous cycle's resolved mode. These cover the straight-through path, the analog, line and diagnostic loop paths, the payload loop, and the all-ones substitutions. They also check that `lb_active` only ever holds a single mode or the line-plus-diagnostic pair. The priority order among conflicting requests, the fact that a losing mode's all-ones option has no effect, and the one-cycle offset between a control change and the data path can only be shown by the bench. It does this by driving chosen request sets and distinct data values and then reading the ports.

// File: rtl/lbr_pkg.sv
package lbr_pkg;
  localparam int unsigned NUM_LB = 4;

  // Bit positions of the status vector; order equals resolution priority.
  localparam int unsigned LB_ANA = 0;
  localparam int unsigned LB_LIN = 1;
  localparam int unsigned LB_DIA = 2;
  localparam int unsigned LB_PAY = 3;

  typedef struct packed {
    logic ana;
    logic lin;
    logic dia;
    logic pay;
    logic ones_to_sys_lin;   // gated by lin
    logic ones_to_line_dia;  // gated by dia
    logic ones_to_sys_pay;   // gated by pay
  } lb_mode_t;
endpackage

// File: rtl/lbr_mode_ctrl.sv
module lbr_mode_ctrl
  import lbr_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                req_ana,
  input  logic                req_lin,
  input  logic                req_dia,
  input  logic                req_pay,
  input  logic                opt_lin_ones,
  input  logic                opt_dia_ones,
  input  logic                opt_pay_ones,
  output lb_mode_t            mode_q,
  output logic [NUM_LB-1:0]   status_q
);
  lb_mode_t mode_d;

  always_comb begin
    mode_d = '0;
    if (req_ana) begin
      mode_d.ana = 1'b1;
    end else if (req_lin) begin
      mode_d.lin = 1'b1;
      // line and diagnostic are the one permitted pair
      mode_d.dia = req_dia;
    end else if (req_dia) begin
      mode_d.dia = 1'b1;
    end else if (req_pay) begin
      mode_d.pay = 1'b1;
    end
    mode_d.ones_to_sys_lin  = mode_d.lin & opt_lin_ones;
    mode_d.ones_to_line_dia = mode_d.dia & opt_dia_ones;
    mode_d.ones_to_sys_pay  = mode_d.pay & opt_pay_ones;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else     mode_q <= mode_d;
  end

  always_comb begin
    status_q         = '0;
    status_q[LB_ANA] = mode_q.ana;
    status_q[LB_LIN] = mode_q.lin;
    status_q[LB_DIA] = mode_q.dia;
    status_q[LB_PAY] = mode_q.pay;
  end
endmodule

// File: rtl/lbr_out_stage.sv
module lbr_out_stage #(
  parameter int unsigned DW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] norm_in,
  input  logic [DW-1:0] loop_in,
  input  logic          use_loop,
  input  logic          force_ones,
  output logic [DW-1:0] q
);
  localparam logic [DW-1:0] ALL_ONES = {DW{1'b1}};

  logic [DW-1:0] d;

  always_comb begin
    if (force_ones)    d = ALL_ONES;
    else if (use_loop) d = loop_in;
    else               d = norm_in;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/lbr_router.sv
module lbr_router
  import lbr_pkg::*;
#(
  parameter int unsigned DW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_analog,
  input  logic          cfg_line,
  input  logic          cfg_diag,
  input  logic          cfg_payload,
  input  logic          cfg_line_ones,
  input  logic          cfg_diag_ones,
  input  logic          cfg_pay_ones,
  input  logic [DW-1:0] line_rx_in,
  input  logic [DW-1:0] fr_tx_in,
  input  logic [DW-1:0] fr_sys_rx_in,
  input  logic [DW-1:0] sys_tx_in,
  output logic [DW-1:0] line_tx_out,
  output logic [DW-1:0] fr_rx_out,
  output logic [DW-1:0] sys_rx_out,
  output logic [DW-1:0] fr_sys_tx_out,
  output logic [3:0]    lb_active
);
  localparam int unsigned NSTREAM = 4;

  lb_mode_t      mode_q;
  logic [NUM_LB-1:0] status_q;

  lbr_mode_ctrl u_mode (
    .clk          (clk),
    .rst          (rst),
    .req_ana      (cfg_analog),
    .req_lin      (cfg_line),
    .req_dia      (cfg_diag),
    .req_pay      (cfg_payload),
    .opt_lin_ones (cfg_line_ones),
    .opt_dia_ones (cfg_diag_ones),
    .opt_pay_ones (cfg_pay_ones),
    .mode_q       (mode_q),
    .status_q     (status_q)
  );

  assign lb_active = status_q;

  // Per-stream selection: index 0 to line, 1 to framer rx, 2 to system, 3 to framer tx payload
  logic [DW-1:0] norm_v [NSTREAM];
  logic [DW-1:0] loop_v [NSTREAM];
  logic [DW-1:0] out_v  [NSTREAM];
  logic [NSTREAM-1:0] use_loop_v;
  logic [NSTREAM-1:0] ones_v;

  always_comb begin
    norm_v[0] = fr_tx_in;     loop_v[0] = line_rx_in;
    norm_v[1] = line_rx_in;   loop_v[1] = fr_tx_in;
    norm_v[2] = fr_sys_rx_in; loop_v[2] = fr_sys_rx_in;
    norm_v[3] = sys_tx_in;    loop_v[3] = fr_sys_rx_in;
    use_loop_v = {mode_q.pay, 1'b0, mode_q.ana | mode_q.dia, mode_q.lin};
    ones_v     = {1'b0,
                  mode_q.ones_to_sys_lin | mode_q.ones_to_sys_pay,
                  1'b0,
                  mode_q.ones_to_line_dia};
  end

  for (genvar i = 0; i < NSTREAM; i++) begin : g_stage
    lbr_out_stage #(.DW(DW)) u_stage (
      .clk        (clk),
      .rst        (rst),
      .norm_in    (norm_v[i]),
      .loop_in    (loop_v[i]),
      .use_loop   (use_loop_v[i]),
      .force_ones (ones_v[i]),
      .q          (out_v[i])
    );
  end

  assign line_tx_out   = out_v[0];
  assign fr_rx_out     = out_v[1];
  assign sys_rx_out    = out_v[2];
  assign fr_sys_tx_out = out_v[3];
endmodule

// File: rtl/lbr_router_chk.sv
module lbr_router_chk
  import lbr_pkg::*;
#(
  parameter int unsigned DW = 1
) (
  input logic          clk,
  input logic          rst,
  input lb_mode_t      mode_q,
  input logic [DW-1:0] line_rx_in,
  input logic [DW-1:0] fr_tx_in,
  input logic [DW-1:0] fr_sys_rx_in,
  input logic [DW-1:0] sys_tx_in,
  input logic [DW-1:0] line_tx_out,
  input logic [DW-1:0] fr_rx_out,
  input logic [DW-1:0] sys_rx_out,
  input logic [DW-1:0] fr_sys_tx_out,
  input logic [3:0]    lb_active
);
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (lb_active == '0 && line_tx_out == '0 && fr_rx_out == '0 &&
             sys_rx_out == '0 && fr_sys_tx_out == '0));

  a_r2_straight: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lb_active) == 4'b0000) |->
      (line_tx_out == $past(fr_tx_in) && fr_rx_out == $past(line_rx_in) &&
       sys_rx_out == $past(fr_sys_rx_in) && fr_sys_tx_out == $past(sys_tx_in)));

  a_r3_analog_loop: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lb_active[0])) |->
      (fr_rx_out == $past(fr_tx_in) && line_tx_out == $past(fr_tx_in)));

  a_r4_line_loop: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lb_active[1]) && !$past(mode_q.ones_to_line_dia)) |->
      line_tx_out == $past(line_rx_in));

  a_r4_line_ones: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_q.ones_to_sys_lin)) |-> sys_rx_out == ONES);

  a_r5_diag_loop: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lb_active[2])) |-> fr_rx_out == $past(fr_tx_in));

  a_r10_ones_first: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode_q.ones_to_line_dia)) |-> line_tx_out == ONES);

  a_r7_payload_loop: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(lb_active[3])) |-> fr_sys_tx_out == $past(fr_sys_rx_in));

  a_r8_status_legal: assert property (@(posedge clk) disable iff (rst)
    ($onehot0(lb_active) || lb_active == 4'b0110));
endmodule

bind lbr_router lbr_router_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mode_q        (mode_q),
  .line_rx_in    (line_rx_in),
  .fr_tx_in      (fr_tx_in),
  .fr_sys_rx_in  (fr_sys_rx_in),
  .sys_tx_in     (sys_tx_in),
  .line_tx_out   (line_tx_out),
  .fr_rx_out     (fr_rx_out),
  .sys_rx_out    (sys_rx_out),
  .fr_sys_tx_out (fr_sys_tx_out),
  .lb_active     (lb_active)
);

// File: tb/lbr_router_tb.sv
module lbr_router_tb;
  localparam int unsigned DW = 4;
  localparam logic [DW-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_analog = 0, cfg_line = 0, cfg_diag = 0, cfg_payload = 0;
  logic cfg_line_ones = 0, cfg_diag_ones = 0, cfg_pay_ones = 0;
  logic [DW-1:0] line_rx_in = '0, fr_tx_in = '0, fr_sys_rx_in = '0, sys_tx_in = '0;
  logic [DW-1:0] line_tx_out, fr_rx_out, sys_rx_out, fr_sys_tx_out;
  logic [3:0] lb_active;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lbr_router #(.DW(DW)) u_dut (
    .clk(clk), .rst(rst),
    .cfg_analog(cfg_analog), .cfg_line(cfg_line), .cfg_diag(cfg_diag),
    .cfg_payload(cfg_payload), .cfg_line_ones(cfg_line_ones),
    .cfg_diag_ones(cfg_diag_ones), .cfg_pay_ones(cfg_pay_ones),
    .line_rx_in(line_rx_in), .fr_tx_in(fr_tx_in), .fr_sys_rx_in(fr_sys_rx_in),
    .sys_tx_in(sys_tx_in), .line_tx_out(line_tx_out), .fr_rx_out(fr_rx_out),
    .sys_rx_out(sys_rx_out), .fr_sys_tx_out(fr_sys_tx_out), .lb_active(lb_active)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // request bits: {analog, line, diag, payload}; ones bits: {line, diag, pay}
  task automatic set_mode(input logic [3:0] req, input logic [2:0] ones);
    {cfg_analog, cfg_line, cfg_diag, cfg_payload} = req;
    {cfg_line_ones, cfg_diag_ones, cfg_pay_ones} = ones;
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] lr, input logic [DW-1:0] ft,
                      input logic [DW-1:0] fs, input logic [DW-1:0] st);
    line_rx_in = lr; fr_tx_in = ft; fr_sys_rx_in = fs; sys_tx_in = st;
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [DW-1:0] lt,
                            input logic [DW-1:0] fr, input logic [DW-1:0] sr,
                            input logic [DW-1:0] fst);
    chk(req, "line_tx_out", 8'(line_tx_out), 8'(lt));
    chk(req, "fr_rx_out", 8'(fr_rx_out), 8'(fr));
    chk(req, "sys_rx_out", 8'(sys_rx_out), 8'(sr));
    chk(req, "fr_sys_tx_out", 8'(fr_sys_tx_out), 8'(fst));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "lb_active", 8'(lb_active), 8'h0);
    expect_out("R1", '0, '0, '0, '0);
  endtask

  task automatic t_straight();
    set_mode(4'b0000, 3'b111);
    chk("R2", "lb_active", 8'(lb_active), 8'h0);
    push(4'h1, 4'h2, 4'h3, 4'h4);
    expect_out("R2", 4'h2, 4'h1, 4'h3, 4'h4);
    push(4'hA, 4'h5, 4'hC, 4'h9);
    expect_out("R2", 4'h5, 4'hA, 4'hC, 4'h9);
  endtask

  task automatic t_analog();
    set_mode(4'b1111, 3'b111);
    chk("R8", "lb_active analog wins", 8'(lb_active), 8'h1);
    push(4'h1, 4'h2, 4'h3, 4'h4);
    expect_out("R3", 4'h2, 4'h2, 4'h3, 4'h4);
  endtask

  task automatic t_line();
    set_mode(4'b0100, 3'b000);
    chk("R8", "lb_active line", 8'(lb_active), 8'h2);
    push(4'h6, 4'h2, 4'h3, 4'h4);
    expect_out("R4", 4'h6, 4'h6, 4'h3, 4'h4);
    set_mode(4'b0100, 3'b100);
    push(4'h7, 4'h2, 4'h3, 4'h4);
    expect_out("R4", 4'h7, 4'h7, ONES, 4'h4);
  endtask

  task automatic t_diag();
    set_mode(4'b0010, 3'b000);
    chk("R8", "lb_active diag", 8'(lb_active), 8'h4);
    push(4'h1, 4'h8, 4'h3, 4'h4);
    expect_out("R5", 4'h8, 4'h8, 4'h3, 4'h4);
    set_mode(4'b0010, 3'b010);
    push(4'h1, 4'h9, 4'h3, 4'h4);
    expect_out("R5", ONES, 4'h9, 4'h3, 4'h4);
  endtask

  task automatic t_line_diag();
    set_mode(4'b0110, 3'b000);
    chk("R6", "lb_active pair", 8'(lb_active), 8'h6);
    push(4'h5, 4'hB, 4'h3, 4'h4);
    expect_out("R6", 4'h5, 4'hB, 4'h3, 4'h4);
    set_mode(4'b0110, 3'b010);
    push(4'h5, 4'hB, 4'h3, 4'h4);
    expect_out("R10", ONES, 4'hB, 4'h3, 4'h4);
  endtask

  task automatic t_payload();
    set_mode(4'b0001, 3'b000);
    chk("R8", "lb_active payload", 8'(lb_active), 8'h8);
    push(4'h1, 4'h2, 4'hD, 4'h4);
    expect_out("R7", 4'h2, 4'h1, 4'hD, 4'hD);
    set_mode(4'b0001, 3'b001);
    push(4'h1, 4'h2, 4'hE, 4'h4);
    expect_out("R7", 4'h2, 4'h1, ONES, 4'hE);
  endtask

  task automatic t_priority();
    // line over payload: payload and its all-ones option have no effect
    set_mode(4'b0101, 3'b001);
    chk("R8", "lb_active line over payload", 8'(lb_active), 8'h2);
    push(4'h6, 4'h2, 4'h3, 4'h4);
    expect_out("R8", 4'h6, 4'h6, 4'h3, 4'h4);
    // diag over payload
    set_mode(4'b0011, 3'b001);
    chk("R8", "lb_active diag over payload", 8'(lb_active), 8'h4);
    push(4'h1, 4'h8, 4'h3, 4'h4);
    expect_out("R8", 4'h8, 4'h8, 4'h3, 4'h4);
  endtask

  task automatic t_timing();
    set_mode(4'b0000, 3'b000);
    push(4'h1, 4'h2, 4'h3, 4'h4);
    // control and data change together: data captured with the old mode
    {cfg_analog, cfg_line, cfg_diag, cfg_payload} = 4'b0100;
    line_rx_in = 4'h6; fr_tx_in = 4'h5;
    @(negedge clk);
    chk("R9", "lb_active updated", 8'(lb_active), 8'h2);
    chk("R9", "line_tx_out old mode", 8'(line_tx_out), 8'h5);
    @(negedge clk);
    chk("R9", "line_tx_out new mode", 8'(line_tx_out), 8'h6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_straight();
    t_analog();
    t_line();
    t_diag();
    t_line_diag();
    t_payload();
    t_priority();
    t_timing();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule